// File: doc/BRIEF.md
# DRAM Extended Mode Register Programming Sequencer

This block sits on the controller side of a graphics DDR DRAM interface. It rewrites the extended mode register and handles the timing around that write. A client offers a configuration through a valid/ack handshake. The fields are a write-recovery count, a termination select, an output-driver select, a low-power self-refresh flag and a DLL enable. Once the request is accepted, the sequencer takes the command bus. It issues a precharge-all command and waits the row-precharge interval. It then issues the extended mode register set command with the assembled address word, waits the mode-register delay, and gives the bus back.

The block also guards read issue. Each time the DLL becomes enabled, the block holds its read-permit output low for a fixed lock window of clock cycles. The DLL can become enabled in two ways: through a programmed word with the DLL enable set, or by a self-refresh exit, which turns the DLL on by itself. During the same request, the block compares the requested write-recovery count against the required recovery time. It raises an error flag when the count is too short for the clock period.

Top module: `emr_prog_seq`

## Requirements
- R1: After reset, `cmd_o` is NOP (2'b00), `addr_o` and `ba_o` are zero, `req_ack` is high, `rd_permit` is low and `cfg_err` is low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ack` are both high. In the cycle after that edge, `cmd_o` carries precharge-all (2'b01).
- R3: The extended mode register set command (2'b10) appears exactly T_RP cycles after the precharge-all cycle. In that cycle `ba_o` is 2'b01 and `addr_o` carries the assembled word. In every other cycle, `addr_o` and `ba_o` are zero.
- R4: Every cycle of the sequence other than the two commands carries NOP. `req_ack` rises again exactly T_MRD cycles after the mode-register command.
- R5: While a sequence runs, `req_ack` stays low and a held `req_valid` starts no second sequence.
- R6: The write-recovery field `cfg_wr[0]`, `cfg_wr[1]` and `cfg_wr[2]` is placed on address bits 4, 5 and 7 respectively.
- R7: The other word bits are laid out as follows. Bits 1:0 carry `cfg_drv`. Bits 3:2 carry `cfg_rtt` (0 disabled, 1 ZQ/4, 2 ZQ/2). Bit 6 is set when the DLL is to be disabled. Bit 8 carries `cfg_lowpwr` (1 selects the 8 ms self-refresh period, 0 the 32 ms one). All higher bits are zero.
- R8: From the cycle after acceptance, `cfg_err` shows whether `cfg_wr` × CLK_PS < TWR_PS for the accepted request. It keeps that value until the next acceptance.
- R9: A mode-register command with the DLL enabled drives `rd_permit` low. `rd_permit` rises first LOCK_CYC cycles after that command's cycle.
- R10: A one-cycle `sr_exit` pulse turns the DLL on and restarts the lockout. `rd_permit` is low from the next cycle and rises first LOCK_CYC cycles after the pulse's cycle.
- R11: A mode-register command with the DLL disabled keeps `rd_permit` low until the DLL is enabled again.
- R12: `rd_permit` is low in every cycle in which the sequencer owns the command bus (`req_ack` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Programming request offered |
| req_ack | output | 1 | Sequencer idle; a request is taken on this edge |
| cfg_wr | input | 3 | Write-recovery count in clock cycles |
| cfg_rtt | input | 2 | Termination select |
| cfg_drv | input | 2 | Output driver select |
| cfg_lowpwr | input | 1 | Low-power self-refresh flag |
| cfg_dll_en | input | 1 | DLL enable |
| sr_exit | input | 1 | One-cycle pulse: device left self-refresh |
| cmd_o | output | 2 | DRAM command: NOP, precharge-all, mode-register set |
| ba_o | output | 2 | Bank address; selects the extended register |
| addr_o | output | ADDR_W | Address bus; mode word during the register command |
| cfg_err | output | 1 | Accepted write-recovery count is too short |
| rd_permit | output | 1 | READ may be issued this cycle |

## Verification
Cycles are counted from the accepting edge. Precharge-all is due in cycle 1, the register command in cycle 1+T_RP, and `req_ack` in cycle 1+T_RP+T_MRD. `cfg_err` is due in cycle 1. A task samples each of these one half-period after the edge that produces it. For `rd_permit`, a monitor records the absolute cycle in which a lock window opens: the register command cycle, or the cycle after an `sr_exit` pulse. It then compares the output every cycle against "DLL on, window elapsed, bus free", sampling 1 ns after the falling edge. The monitor therefore catches a rise that comes one cycle early or late.

// File: rtl/emr_seq_pkg.sv
// Package: shared types for the extended mode register sequencer.
// Assumes: a two-bit command code is enough for the commands issued here.
package emr_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP    = 2'b00,
        CMD_PREALL = 2'b01,
        CMD_EMRS   = 2'b10
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREALL,
        ST_WAIT_RP,
        ST_EMRS,
        ST_WAIT_MRD
    } seq_state_e;

    typedef struct packed {
        logic [2:0] wr_cyc;
        logic [1:0] odt_sel;
        logic [1:0] drv_sel;
        logic       low_pwr;
        logic       dll_on;
    } emr_cfg_t;

    localparam int EMR_FIELD_BITS = 9;

endpackage

// File: rtl/emr_word_build.sv
// Module: emr_word_build
// Turns a configuration record into the extended mode register address word.
// It also checks the write-recovery count against the recovery time.
// Assumes: ADDR_W >= EMR_FIELD_BITS; CLK_PS and TWR_PS are given in picoseconds.
module emr_word_build
    import emr_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CLK_PS = 5000,
    parameter int TWR_PS = 15000
) (
    input  emr_cfg_t          cfg,
    output logic [ADDR_W-1:0] word,
    output logic              wr_short
);

    localparam int PAD_W = ADDR_W - EMR_FIELD_BITS;

    logic [EMR_FIELD_BITS-1:0] fields;
    logic [31:0]               wr_time_ps;

    // Purpose: place each configuration field on its address bits.
    always_comb begin
        fields[1:0] = cfg.drv_sel;
        fields[3:2] = cfg.odt_sel;
        fields[4]   = cfg.wr_cyc[0];
        fields[5]   = cfg.wr_cyc[1];
        fields[6]   = ~cfg.dll_on;
        fields[7]   = cfg.wr_cyc[2];
        fields[8]   = cfg.low_pwr;
    end

    // Zero-fill the bits above the defined fields when the bus is wider.
    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, fields};
        end else begin : g_nopad
            assign word = fields[ADDR_W-1:0];
        end
    endgenerate

    // Purpose: flag a recovery count whose duration falls short of TWR_PS.
    always_comb begin
        wr_time_ps = 32'(cfg.wr_cyc) * 32'(CLK_PS);
        wr_short   = (wr_time_ps < 32'(TWR_PS));
    end

endmodule

// File: rtl/emr_seq_fsm.sv
// Module: emr_seq_fsm
// Drives the command sequence: precharge-all, the row-precharge wait,
// the mode-register command, the mode-register wait, then idle.
// Assumes: T_RP >= 1 and T_MRD >= 1, both in clock cycles.
module emr_seq_fsm
    import emr_seq_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_MRD = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    output logic      req_ack,
    output logic      accept,
    output logic      emrs_fire,
    output logic      busy,
    output dram_cmd_e cmd
);

    localparam int CNT_MAX = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] wait_cnt;

    assign req_ack   = (state == ST_IDLE);
    assign accept    = req_valid && req_ack;
    assign emrs_fire = (state == ST_EMRS);
    assign busy      = !req_ack;

    // Purpose: map the current state to the command on the bus.
    always_comb begin
        unique case (state)
            ST_PREALL: cmd = CMD_PREALL;
            ST_EMRS:   cmd = CMD_EMRS;
            default:   cmd = CMD_NOP;
        endcase
    end

    // Purpose: advance the sequence and count down each wait interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_PREALL;
                        wait_cnt <= RP_LOAD;
                    end
                end
                ST_PREALL, ST_WAIT_RP: begin
                    if (wait_cnt == '0) begin
                        state    <= ST_EMRS;
                        wait_cnt <= MRD_LOAD;
                    end else begin
                        state    <= ST_WAIT_RP;
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                ST_EMRS, ST_WAIT_MRD: begin
                    if (wait_cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        state    <= ST_WAIT_MRD;
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dll_lock_timer.sv
// Module: dll_lock_timer
// Tracks whether the DLL is on and holds off READ for LOCK_CYC cycles
// after each enable: a mode-register write with the DLL set, or a
// self-refresh exit. Reads are also held off while the bus is busy.
// Assumes: LOCK_CYC >= 2; sr_exit is a single-cycle pulse.
module dll_lock_timer #(
    parameter int LOCK_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic emrs_fire,
    input  logic dll_on_req,
    input  logic sr_exit,
    input  logic busy,
    output logic rd_permit
);

    localparam int LCK_W = $clog2(LOCK_CYC);
    localparam logic [LCK_W-1:0] LCK_LOAD = LCK_W'(LOCK_CYC - 1);

    logic             dll_q;
    logic [LCK_W-1:0] lock_cnt;

    // Purpose: load the lock window on each enable event, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_q    <= 1'b0;
            lock_cnt <= '0;
        end else if (emrs_fire) begin
            dll_q    <= dll_on_req;
            lock_cnt <= dll_on_req ? LCK_LOAD : '0;
        end else if (sr_exit) begin
            dll_q    <= 1'b1;
            lock_cnt <= LCK_LOAD;
        end else if (lock_cnt != '0) begin
            lock_cnt <= lock_cnt - 1'b1;
        end
    end

    assign rd_permit = dll_q && (lock_cnt == '0) && !busy;

endmodule

// File: rtl/emr_prog_seq.sv
// Module: emr_prog_seq (top)
// Takes a configuration on a valid/ack handshake, captures it, and runs the
// precharge-all / mode-register sequence. It shows the word on the address
// bus only in the command cycle and reports the read lockout.
// Assumes: a single clock domain; the configuration is valid with req_valid.
module emr_prog_seq
    import emr_seq_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int T_RP     = 3,
    parameter int T_MRD    = 4,
    parameter int LOCK_CYC = 1000,
    parameter int CLK_PS   = 5000,
    parameter int TWR_PS   = 15000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ack,
    input  logic [2:0]        cfg_wr,
    input  logic [1:0]        cfg_rtt,
    input  logic [1:0]        cfg_drv,
    input  logic              cfg_lowpwr,
    input  logic              cfg_dll_en,
    input  logic              sr_exit,
    output logic [1:0]        cmd_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cfg_err,
    output logic              rd_permit
);

    localparam logic [1:0] EMR_BANK = 2'b01;

    emr_cfg_t          cfg_in;
    emr_cfg_t          cfg_q;
    logic [ADDR_W-1:0] word;
    logic              wr_short_in;
    logic              wr_short_unused;
    logic              accept;
    logic              emrs_fire;
    logic              busy;
    dram_cmd_e         cmd;

    // Purpose: gather the configuration ports into one record.
    always_comb begin
        cfg_in.wr_cyc  = cfg_wr;
        cfg_in.odt_sel = cfg_rtt;
        cfg_in.drv_sel = cfg_drv;
        cfg_in.low_pwr = cfg_lowpwr;
        cfg_in.dll_on  = cfg_dll_en;
    end

    // Evaluates the recovery check on the incoming request.
    emr_word_build #(
        .ADDR_W (ADDR_W),
        .CLK_PS (CLK_PS),
        .TWR_PS (TWR_PS)
    ) u_chk_in (
        .cfg      (cfg_in),
        .word     (),
        .wr_short (wr_short_in)
    );

    // Builds the word from the captured configuration.
    emr_word_build #(
        .ADDR_W (ADDR_W),
        .CLK_PS (CLK_PS),
        .TWR_PS (TWR_PS)
    ) u_word (
        .cfg      (cfg_q),
        .word     (word),
        .wr_short (wr_short_unused)
    );

    emr_seq_fsm #(
        .T_RP  (T_RP),
        .T_MRD (T_MRD)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ack   (req_ack),
        .accept    (accept),
        .emrs_fire (emrs_fire),
        .busy      (busy),
        .cmd       (cmd)
    );

    dll_lock_timer #(
        .LOCK_CYC (LOCK_CYC)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .emrs_fire  (emrs_fire),
        .dll_on_req (cfg_q.dll_on),
        .sr_exit    (sr_exit),
        .busy       (busy),
        .rd_permit  (rd_permit)
    );

    // Purpose: capture the configuration and its recovery check on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            cfg_err <= 1'b0;
        end else if (accept) begin
            cfg_q   <= cfg_in;
            cfg_err <= wr_short_in;
        end
    end

    assign cmd_o  = cmd;
    assign addr_o = emrs_fire ? word : '0;
    assign ba_o   = emrs_fire ? EMR_BANK : 2'b00;

endmodule

// File: rtl/emr_prog_seq_chk.sv
// Module: emr_prog_seq_chk
// Checker for the sequencer's port-level timing rules, bound to the top.
// Assumes: T_RP >= 1 so precharge-all is never repeated back to back.
module emr_prog_seq_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ack,
    input logic              sr_exit,
    input logic [1:0]        cmd_o,
    input logic [1:0]        ba_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              rd_permit
);

    // R2: an accepted request puts precharge-all on the bus next cycle
    a_r2_preall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> (cmd_o == 2'b01));

    // R5: no command is issued while the block reports idle
    a_r5_ack_low_when_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'b00) |-> !req_ack);

    // R3: address and bank are quiet outside the register command
    a_r3_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'b10) |-> ((addr_o == '0) && (ba_o == 2'b00)));

    // R4: precharge-all is followed by a NOP cycle or the register command
    a_r4_no_double_preall: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b01) |=> (cmd_o != 2'b01));

    // R12: reads are never permitted while the bus is held
    a_r12_no_permit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ack |-> !rd_permit);

    // R9: the register command closes the read window
    a_r9_emrs_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b10) |=> !rd_permit);

    // R10: a self-refresh exit closes the read window next cycle
    a_r10_srx_closes: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |=> !rd_permit);

endmodule

bind emr_prog_seq emr_prog_seq_chk #(.ADDR_W(ADDR_W)) u_prog_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .sr_exit   (sr_exit),
    .cmd_o     (cmd_o),
    .ba_o      (ba_o),
    .addr_o    (addr_o),
    .rd_permit (rd_permit)
);

// File: tb/tb_emr_prog_seq.sv
`timescale 1ns/1ps
module tb_emr_prog_seq;

    localparam int ADDR_W   = 12;
    localparam int T_RP     = 3;
    localparam int T_MRD    = 4;
    localparam int LOCK_CYC = 1000;
    localparam int CLK_PS   = 5000;
    localparam int TWR_PS   = 15000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ack;
    logic [2:0]        cfg_wr = '0;
    logic [1:0]        cfg_rtt = '0;
    logic [1:0]        cfg_drv = '0;
    logic              cfg_lowpwr = 1'b0;
    logic              cfg_dll_en = 1'b0;
    logic              sr_exit = 1'b0;
    logic [1:0]        cmd_o;
    logic [1:0]        ba_o;
    logic [ADDR_W-1:0] addr_o;
    logic              cfg_err;
    logic              rd_permit;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    longint      cyc = 0;
    longint      lock_ready_at = 0;
    bit          dll_model = 0;
    bit          busy_model = 0;
    bit          mon_on = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    emr_prog_seq #(
        .ADDR_W(ADDR_W), .T_RP(T_RP), .T_MRD(T_MRD),
        .LOCK_CYC(LOCK_CYC), .CLK_PS(CLK_PS), .TWR_PS(TWR_PS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
        .cfg_wr(cfg_wr), .cfg_rtt(cfg_rtt), .cfg_drv(cfg_drv),
        .cfg_lowpwr(cfg_lowpwr), .cfg_dll_en(cfg_dll_en), .sr_exit(sr_exit),
        .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o),
        .cfg_err(cfg_err), .rd_permit(rd_permit)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // R6, R7: expected mode word from the requirement's bit layout
    function automatic logic [ADDR_W-1:0] exp_word(input logic [2:0] wr, input logic [1:0] rtt,
                                                    input logic [1:0] drv, input logic lp,
                                                    input logic dll);
        logic [ADDR_W-1:0] w;
        w = '0;
        w[1:0] = drv;
        w[3:2] = rtt;
        w[4]   = wr[0];
        w[5]   = wr[1];
        w[6]   = !dll;
        w[7]   = wr[2];
        w[8]   = lp;
        return w;
    endfunction

    // R8: expected recovery flag
    function automatic bit exp_err(input logic [2:0] wr);
        return (int'(wr) * CLK_PS) < TWR_PS;
    endfunction

    // R9-style rule evaluated per cycle: R12 busy gate, R9/R10 window, R11 off
    always @(negedge clk) begin
        #1;
        if (mon_on && !done)
            check("R9 R10 R11 R12 rd_permit", rd_permit,
                  (dll_model && !busy_model && cyc >= lock_ready_at) ? 1 : 0);
    end

    task automatic run_seq(input logic [2:0] wr, input logic [1:0] rtt, input logic [1:0] drv,
                           input logic lp, input logic dll);
        logic [ADDR_W-1:0] w;
        w = exp_word(wr, rtt, drv, lp, dll);
        @(negedge clk);
        check("R5 ack idle before request", req_ack, 1);
        req_valid  = 1'b1;
        cfg_wr     = wr;
        cfg_rtt    = rtt;
        cfg_drv    = drv;
        cfg_lowpwr = lp;
        cfg_dll_en = dll;
        for (int k = 1; k <= T_RP + T_MRD + 1; k++) begin
            @(negedge clk);
            busy_model = (k <= T_RP + T_MRD);
            if (k == 1 + T_RP) begin
                dll_model     = dll;
                lock_ready_at = cyc + LOCK_CYC;
            end
            if (k == 1) begin
                check("R2 preall after accept", cmd_o, 2'b01);
                check("R8 cfg_err", cfg_err, exp_err(wr));
                // change inputs under a held request: must not leak (R5)
                cfg_wr = ~wr;
            end else if (k == 1 + T_RP) begin
                check("R3 emrs cmd", cmd_o, 2'b10);
                check("R3 emrs bank", ba_o, 2'b01);
                check("R6 R7 emrs word", addr_o, w);
            end else begin
                check("R4 nop fill", cmd_o, 2'b00);
                check("R3 addr quiet", addr_o, 0);
            end
            if (k <= T_RP + T_MRD) check("R5 ack low busy", req_ack, 0);
            else                   check("R4 ack back after mrd", req_ack, 1);
            if (k == T_RP + T_MRD) req_valid = 1'b0;
        end
        @(negedge clk);
        check("R5 no second sequence", cmd_o, 2'b00);
        check("R8 cfg_err held", cfg_err, exp_err(wr));
    endtask

    task automatic pulse_srx();
        @(negedge clk);
        sr_exit = 1'b1;
        @(negedge clk);
        sr_exit       = 1'b0;
        dll_model     = 1;
        lock_ready_at = cyc + LOCK_CYC - 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'h5EC0_0D17));
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cmd", cmd_o, 0);
        check("R1 addr", addr_o, 0);
        check("R1 bank", ba_o, 0);
        check("R1 ack", req_ack, 1);
        check("R1 permit", rd_permit, 0);
        check("R1 err", cfg_err, 0);
        mon_on = 1;

        // R6 R8 boundary: wr=2 too short, wr=3 exactly meets
        run_seq(3'd2, 2'd1, 2'd0, 1'b0, 1'b1);
        run_seq(3'd3, 2'd2, 2'd3, 1'b1, 1'b1);
        idle(LOCK_CYC + 5);
        check("R9 permit after lock window", rd_permit, 1);
        // R11 DLL disabled drops permit
        run_seq(3'd7, 2'd0, 2'd1, 1'b0, 1'b0);
        idle(LOCK_CYC + 5);
        check("R11 permit stays low", rd_permit, 0);
        // R10 self-refresh exit enables DLL and restarts the lockout
        pulse_srx();
        idle(LOCK_CYC - 3);
        check("R10 permit still low", rd_permit, 0);
        idle(5);
        check("R10 permit after srx window", rd_permit, 1);
        run_seq(3'd0, 2'd3, 2'd2, 1'b1, 1'b1);

        for (int it = 0; it < 16; it++) begin
            run_seq(3'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
            idle(int'($urandom % 40));
            if ($urandom % 3 == 0) pulse_srx();
            if (it % 4 == 3) idle(LOCK_CYC + 10);
        end
        idle(LOCK_CYC + 10);
        done = 1;
        report();
    end

endmodule